// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD. A sub-second divider counts `CLK_HZ` cycles of the input clock and issues one tick per second. Each tick starts a short carry sequence that steps the seconds. When a field wraps, the sequence goes on to minutes, then hours, then the day (day-of-week and date together), then the month and then the year. The divider length is a parameter, so a simulation can use a small value.

A host loads any field through a one-hot strobe vector and a shared data byte. Bit 7 of the seconds field is a halt flag: while it is 1, the divider and the counting stop. Any write to the seconds field restarts the divider from zero. This also aligns the optional 1 Hz square wave, which goes high half a second after that write. The hours field has a format bit (bit 6). It selects either 12-hour counting, where bit 5 is the PM flag, or 24-hour counting, where bit 5 is the twenty digit of the hour.

The carry sequencer is a state machine with the states S_IDLE, S_SEC, S_MIN, S_HOUR, S_DAY, S_MONTH and S_YEAR. Its transitions are as follows:
- S_IDLE goes to S_SEC on a divider tick.
- S_SEC goes to S_MIN if seconds were at 59, otherwise to S_IDLE.
- S_MIN goes to S_HOUR if minutes were at 59, otherwise to S_IDLE.
- S_HOUR goes to S_DAY on midnight rollover, otherwise to S_IDLE.
- S_DAY goes to S_MONTH if the date was the last day of the month, otherwise to S_IDLE.
- S_MONTH goes to S_YEAR if the month was 12, otherwise to S_IDLE.
- S_YEAR always returns to S_IDLE.

Each state steps exactly one field. A host write to a field takes priority over a step of that same field in the same cycle.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the fields read as follows: seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour), day-of-week 0x01, date 0x01, month 0x01 and year 0x00. The square-wave output is low.
- R2: While running, the seconds advance by one BCD step once per `CLK_HZ` clock cycles, and 0x59 wraps to 0x00.
- R3: While seconds bit 7 is 1, no field advances and the square-wave output stays low.
- R4: A write to seconds restarts the divider. The seconds value changes on the (`CLK_HZ`+1)-th rising edge after the write edge and not before.
- R5: With `sqw_en`=1 and running, `sqw_o` rises on the `CLK_HZ`/2-th edge after a seconds write and falls on the `CLK_HZ`-th edge. With `sqw_en`=0 it stays low.
- R6: In 24-hour mode (hours bit 6 = 0), hours run 0x00–0x23 with bit 5 as the twenty digit. 0x23 wraps to 0x00 and carries into the day.
- R7: In 12-hour mode (hours bit 6 = 1, bit 5 = PM), 11 steps to 12 and toggles PM. 12 steps to 1 without toggling. Only 11 PM to 12 AM carries into the day.
- R8: Day-of-week (bits 2:0) steps at each day carry and wraps from 7 to 1.
- R9: The date wraps to 0x01 after 0x30 for months 4, 6, 9 and 11. It wraps after 0x31 for the other months. For February it wraps after 0x29 when the year value is a multiple of 4, and after 0x28 otherwise.
- R10: A date wrap steps the month. Month 0x12 wraps to 0x01 and steps the year in BCD, and 0x99 wraps to 0x00.
- R11: Each field write strobe loads its field on the next edge. Unused bits are dropped and read as 0: minutes keep bits 6:0 and day-of-week keeps bits 2:0.
- R12: A minutes value of 0x59 at a seconds wrap becomes 0x00 and carries into hours. Otherwise minutes step by one and hours are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLK_HZ` cycles per second |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 7 | Field load strobes: 0 sec, 1 min, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year |
| wr_data | input | 8 | Data for the strobed field |
| sqw_en | input | 1 | Enables the 1 Hz square wave |
| sec_o | output | 8 | Halt flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hr_o | output | 8 | Format bit, PM/twenty bit and BCD hours |
| dow_o | output | 8 | Day-of-week 1–7 |
| date_o | output | 8 | BCD date |
| mon_o | output | 8 | BCD month |
| yr_o | output | 8 | BCD year |
| sqw_o | output | 1 | 1 Hz square wave |

## Verification
The bench targets the 12-hour corners: 11 AM to 12 PM, 12 PM to 1 PM and 11 PM to 12 AM. A design that toggled PM at the wrong step, or carried into the day at noon, would show a wrong hour or an early day change. It also drives every month-length case, including February in leap and non-leap years and the December/99 double wrap. A wrong length table there would show the date reaching 0x31 in a short month, or 0x29 in a common-year February. The exact cycle of the first second after a seconds write is checked, and so is the square-wave edge. Off-by-one divider logic, or a divider that ignores the write, would move those edges. The halt flag and the field masks are checked through the outputs after stimulus.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef enum logic [2:0] {
        S_IDLE, S_SEC, S_MIN, S_HOUR, S_DAY, S_MONTH, S_YEAR
    } step_state_t;

    typedef struct packed {
        logic [6:0] val;
        logic       midnight;
    } hour_step_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        logic [7:0] bin;
        bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [5:0] month_len(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic hour_step_t hour_next(input logic [6:0] h);
        hour_step_t r;
        logic [7:0] t;
        r.midnight = 1'b0;
        if (!h[6]) begin
            if (h[5:0] == 6'h23) begin
                r.val      = 7'h00;
                r.midnight = 1'b1;
            end else begin
                t     = bcd_inc({2'b00, h[5:0]});
                r.val = {1'b0, t[5:0]};
            end
        end else begin
            if (h[4:0] == 5'h12) begin
                r.val = {1'b1, h[5], 5'h01};
            end else if (h[4:0] == 5'h11) begin
                r.val      = {1'b1, ~h[5], 5'h12};
                r.midnight = h[5];
            end else begin
                t     = bcd_inc({3'b000, h[4:0]});
                r.val = {1'b1, h[5], t[4:0]};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tk_divider.sv
module tk_divider #(
    parameter int CLK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic sqw_en,
    output logic tick,
    output logic sqw
);
    localparam int CW   = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam int LAST = CLK_HZ - 1;
    localparam int HALF = CLK_HZ / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == CW'(LAST)) ? '0 : cnt + 1'b1;
    end

    always_comb begin
        tick = run && !restart && (cnt == CW'(LAST));
        sqw  = sqw_en && run && (cnt >= CW'(HALF));
    end

    // R4: a seconds write leaves the divider at zero
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R2: at most one tick per period
    a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tk_step_fsm.sv
module tk_step_fsm
    import tk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sec_wrap,
    input  logic min_wrap,
    input  logic hr_wrap,
    input  logic date_wrap,
    input  logic mon_wrap,
    output logic step_sec,
    output logic step_min,
    output logic step_hr,
    output logic step_day,
    output logic step_mon,
    output logic step_yr
);
    step_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = S_IDLE;
        unique case (state)
            S_IDLE:  nxt = tick      ? S_SEC   : S_IDLE;
            S_SEC:   nxt = sec_wrap  ? S_MIN   : S_IDLE;
            S_MIN:   nxt = min_wrap  ? S_HOUR  : S_IDLE;
            S_HOUR:  nxt = hr_wrap   ? S_DAY   : S_IDLE;
            S_DAY:   nxt = date_wrap ? S_MONTH : S_IDLE;
            S_MONTH: nxt = mon_wrap  ? S_YEAR  : S_IDLE;
            S_YEAR:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        step_sec = 1'b0;
        step_min = 1'b0;
        step_hr  = 1'b0;
        step_day = 1'b0;
        step_mon = 1'b0;
        step_yr  = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_SEC:   step_sec = 1'b1;
            S_MIN:   step_min = 1'b1;
            S_HOUR:  step_hr  = 1'b1;
            S_DAY:   step_day = 1'b1;
            S_MONTH: step_mon = 1'b1;
            S_YEAR:  step_yr  = 1'b1;
            default: ;
        endcase
    end

    // R12: minutes are only stepped right after a seconds step
    a_r12_min_after_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MIN) |-> ($past(state) == S_SEC));

    // R10: the year is only stepped right after a month step
    a_r10_year_after_month: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_YEAR) |-> ($past(state) == S_MONTH));

endmodule

// File: rtl/tk_time_regs.sv
module tk_time_regs
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hr,
    input  logic [7:0] wr_data,
    input  logic       step_sec,
    input  logic       step_min,
    input  logic       step_hr,
    output logic [7:0] sec_q,
    output logic [6:0] min_q,
    output logic [6:0] hr_q,
    output logic       sec_wrap,
    output logic       min_wrap,
    output logic       hr_wrap,
    output logic       halt
);
    logic [7:0] sec_nx;
    logic [6:0] min_nx;
    hour_step_t hstep;

    always_comb begin
        sec_wrap = (sec_q[6:0] == 7'h59);
        min_wrap = (min_q == 7'h59);
        hstep    = hour_next(hr_q);
        hr_wrap  = hstep.midnight;
        halt     = sec_q[7];
        sec_nx   = sec_wrap ? {sec_q[7], 7'h00}
                            : {sec_q[7], 7'(bcd_inc({1'b0, sec_q[6:0]}))};
        min_nx   = min_wrap ? 7'h00 : 7'(bcd_inc({1'b0, min_q}));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= 8'h00;
            min_q <= 7'h00;
            hr_q  <= 7'h00;
        end else begin
            if (wr_sec)        sec_q <= wr_data;
            else if (step_sec) sec_q <= sec_nx;
            if (wr_min)        min_q <= wr_data[6:0];
            else if (step_min) min_q <= min_nx;
            if (wr_hr)         hr_q  <= wr_data[6:0];
            else if (step_hr)  hr_q  <= hstep.val;
        end
    end

    // R2: a seconds step always changes the count
    a_r2_sec_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step_sec && !wr_sec) |=> (sec_q[6:0] != $past(sec_q[6:0])));

    // R6: 24-hour stepping stays within 00..23
    a_r6_hr24_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hr && !wr_hr && !hr_q[6] && hr_q[5:0] <= 6'h23) |=> (hr_q[5:0] <= 6'h23));

    // R7: PM flag only changes on the 11 to 12 step
    a_r7_pm_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hr && !wr_hr && hr_q[6] && hr_q[4:0] != 5'h11) |=> (hr_q[5] == $past(hr_q[5])));

endmodule

// File: rtl/tk_date_regs.sv
module tk_date_regs
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_dow,
    input  logic       wr_date,
    input  logic       wr_mon,
    input  logic       wr_yr,
    input  logic [7:0] wr_data,
    input  logic       step_day,
    input  logic       step_mon,
    input  logic       step_yr,
    output logic [2:0] dow_q,
    output logic [5:0] date_q,
    output logic [4:0] mon_q,
    output logic [7:0] yr_q,
    output logic       date_wrap,
    output logic       mon_wrap
);
    logic [2:0] dow_nx;
    logic [5:0] date_nx;
    logic [4:0] mon_nx;
    logic [7:0] yr_nx;
    logic [5:0] last_day;

    always_comb begin
        last_day  = month_len(mon_q, yr_q);
        date_wrap = (date_q == last_day);
        mon_wrap  = (mon_q == 5'h12);
        dow_nx    = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
        date_nx   = date_wrap ? 6'h01 : 6'(bcd_inc({2'b00, date_q}));
        mon_nx    = mon_wrap  ? 5'h01 : 5'(bcd_inc({3'b000, mon_q}));
        yr_nx     = (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dow_q  <= 3'd1;
            date_q <= 6'h01;
            mon_q  <= 5'h01;
            yr_q   <= 8'h00;
        end else begin
            if (wr_dow)        dow_q  <= wr_data[2:0];
            else if (step_day) dow_q  <= dow_nx;
            if (wr_date)       date_q <= wr_data[5:0];
            else if (step_day) date_q <= date_nx;
            if (wr_mon)        mon_q  <= wr_data[4:0];
            else if (step_mon) mon_q  <= mon_nx;
            if (wr_yr)         yr_q   <= wr_data;
            else if (step_yr)  yr_q   <= yr_nx;
        end
    end

    // R8: day-of-week wraps from 7 to 1
    a_r8_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_day && !wr_dow && dow_q == 3'd7) |=> (dow_q == 3'd1));

    // R9: a date wrap restarts the month at day 01
    a_r9_date_first: assert property (@(posedge clk) disable iff (!rst_n)
        (step_day && !wr_date && date_wrap) |=> (date_q == 6'h01));

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter int CLK_HZ = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FIELDS-1:0] wr_en,
    input  logic [7:0]            wr_data,
    input  logic                  sqw_en,
    output logic [7:0]            sec_o,
    output logic [7:0]            min_o,
    output logic [7:0]            hr_o,
    output logic [7:0]            dow_o,
    output logic [7:0]            date_o,
    output logic [7:0]            mon_o,
    output logic [7:0]            yr_o,
    output logic                  sqw_o
);
    logic       tick, halt;
    logic       sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap;
    logic       step_sec, step_min, step_hr, step_day, step_mon, step_yr;
    logic [7:0] sec_q;
    logic [6:0] min_q, hr_q;
    logic [2:0] dow_q;
    logic [5:0] date_q;
    logic [4:0] mon_q;
    logic [7:0] yr_q;
    logic       step_any;

    tk_divider #(.CLK_HZ(CLK_HZ)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en[F_SEC]),
        .run     (!halt),
        .sqw_en  (sqw_en),
        .tick    (tick),
        .sqw     (sqw_o)
    );

    tk_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sec_wrap  (sec_wrap),
        .min_wrap  (min_wrap),
        .hr_wrap   (hr_wrap),
        .date_wrap (date_wrap),
        .mon_wrap  (mon_wrap),
        .step_sec  (step_sec),
        .step_min  (step_min),
        .step_hr   (step_hr),
        .step_day  (step_day),
        .step_mon  (step_mon),
        .step_yr   (step_yr)
    );

    tk_time_regs u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sec   (wr_en[F_SEC]),
        .wr_min   (wr_en[F_MIN]),
        .wr_hr    (wr_en[F_HOUR]),
        .wr_data  (wr_data),
        .step_sec (step_sec),
        .step_min (step_min),
        .step_hr  (step_hr),
        .sec_q    (sec_q),
        .min_q    (min_q),
        .hr_q     (hr_q),
        .sec_wrap (sec_wrap),
        .min_wrap (min_wrap),
        .hr_wrap  (hr_wrap),
        .halt     (halt)
    );

    tk_date_regs u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dow    (wr_en[F_DOW]),
        .wr_date   (wr_en[F_DATE]),
        .wr_mon    (wr_en[F_MON]),
        .wr_yr     (wr_en[F_YEAR]),
        .wr_data   (wr_data),
        .step_day  (step_day),
        .step_mon  (step_mon),
        .step_yr   (step_yr),
        .dow_q     (dow_q),
        .date_q    (date_q),
        .mon_q     (mon_q),
        .yr_q      (yr_q),
        .date_wrap (date_wrap),
        .mon_wrap  (mon_wrap)
    );

    always_comb begin
        sec_o    = sec_q;
        min_o    = {1'b0, min_q};
        hr_o     = {1'b0, hr_q};
        dow_o    = {5'b0, dow_q};
        date_o   = {2'b0, date_q};
        mon_o    = {3'b0, mon_q};
        yr_o     = yr_q;
        step_any = step_sec | step_min | step_hr | step_day | step_mon | step_yr;
    end

    // R3: once the sequence is idle, a halted counter never starts a step
    a_r3_halt_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !step_any) |=> !step_any);

    // R5: square wave never high while halted
    a_r5_sqw_halt_low: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(halt)) |-> !sqw_o);

endmodule

// File: tb/bcd_timekeeper_test.sv
`timescale 1ns/1ps
module bcd_timekeeper_test;
    import tk_pkg::*;

    localparam int HZ   = 16;
    localparam int HALF = HZ / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] wr_en = '0;
    logic [7:0] wr_data = '0;
    logic       sqw_en = 1'b0;
    logic [7:0] sec_o, min_o, hr_o, dow_o, date_o, mon_o, yr_o;
    logic       sqw_o;

    always #2.5 clk = ~clk;

    bcd_timekeeper #(.CLK_HZ(HZ)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sqw_en(sqw_en), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o),
        .dow_o(dow_o), .date_o(date_o), .mon_o(mon_o), .yr_o(yr_o),
        .sqw_o(sqw_o)
    );

    typedef struct {
        int         idx;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    event  chk_ev;

    function automatic logic [7:0] observe(input int idx);
        case (idx)
            0: return sec_o;
            1: return min_o;
            2: return hr_o;
            3: return dow_o;
            4: return date_o;
            5: return mon_o;
            6: return yr_o;
            default: return {7'b0, sqw_o};
        endcase
    endfunction

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = observe(it.idx);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s field %0d: actual=%h expected=%h", it.tag, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int idx, input logic [7:0] v, input string tag);
        item_t it;
        it.idx = idx; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic wr(input int idx, input logic [7:0] v);
        wr_en        = '0;
        wr_en[idx]   = 1'b1;
        wr_data      = v;
        @(negedge clk);
        wr_en        = '0;
    endtask

    task automatic roll(input logic [7:0] s, m, h, dw, dt, mo, y,
                        input logic [7:0] es, em, eh, edw, edt, emo, ey,
                        input string tag);
        wr(F_SEC, 8'h80);
        repeat (8) @(negedge clk);
        wr(F_MIN, m); wr(F_HOUR, h); wr(F_DOW, dw);
        wr(F_DATE, dt); wr(F_MON, mo); wr(F_YEAR, y);
        wr(F_SEC, s);
        repeat (HZ + 10) @(negedge clk);
        push(F_SEC, es, tag);  push(F_MIN, em, tag);  push(F_HOUR, eh, tag);
        push(F_DOW, edw, tag); push(F_DATE, edt, tag); push(F_MON, emo, tag);
        push(F_YEAR, ey, tag);
        flush();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        push(F_SEC, 8'h00, "R1"); push(F_MIN, 8'h00, "R1"); push(F_HOUR, 8'h00, "R1");
        push(F_DOW, 8'h01, "R1"); push(F_DATE, 8'h01, "R1"); push(F_MON, 8'h01, "R1");
        push(F_YEAR, 8'h00, "R1"); push(7, 8'h00, "R1");
        flush();

        // R4 / R5 exact timing after a seconds write
        sqw_en = 1'b1;
        wr(F_SEC, 8'h10);
        for (int n = 1; n <= HZ + 1; n++) begin
            @(negedge clk);
            if (n == HALF - 1) push(7, 8'h00, "R5 before rise");
            if (n == HALF)     push(7, 8'h01, "R5 rise");
            if (n == HZ) begin
                push(7, 8'h00, "R5 fall");
                push(F_SEC, 8'h10, "R4 before step");
            end
            if (n == HZ + 1)   push(F_SEC, 8'h11, "R4 R2 step");
            flush();
        end

        // R5 disabled output stays low
        sqw_en = 1'b0;
        wr(F_SEC, 8'h20);
        for (int n = 1; n <= HZ; n++) begin
            @(negedge clk);
            if (n == HALF || n == HALF + 3) begin
                push(7, 8'h00, "R5 disabled");
                flush();
            end
        end

        // R6 R8 R9 R10 R12: full rollover to the new century wrap
        roll(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99,
             8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R6 R8 R10 full wrap");
        // R7 11 PM -> 12 AM, leap February 28 -> 29
        roll(8'h59, 8'h59, 8'h71, 8'h03, 8'h28, 8'h02, 8'h24,
             8'h00, 8'h00, 8'h52, 8'h04, 8'h29, 8'h02, 8'h24, "R7 R9 midnight leap");
        // R9 leap February 29 -> March 1
        roll(8'h59, 8'h59, 8'h23, 8'h05, 8'h29, 8'h02, 8'h96,
             8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h03, 8'h96, "R9 leap end");
        // R9 common-year February 28 -> March 1
        roll(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23,
             8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23, "R9 common Feb");
        // R9 30-day month
        roll(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h10,
             8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h10, "R9 April");
        // R9 31-day month
        roll(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h05,
             8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h02, 8'h05, "R9 January");
        // R10 BCD year digit carry
        roll(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h19,
             8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h01, 8'h20, "R10 year digit");
        // R7 11 AM -> 12 PM, no day carry
        roll(8'h59, 8'h59, 8'h51, 8'h02, 8'h15, 8'h06, 8'h30,
             8'h00, 8'h00, 8'h72, 8'h02, 8'h15, 8'h06, 8'h30, "R7 noon");
        // R7 12 PM -> 1 PM, PM kept
        roll(8'h59, 8'h59, 8'h72, 8'h02, 8'h15, 8'h06, 8'h30,
             8'h00, 8'h00, 8'h61, 8'h02, 8'h15, 8'h06, 8'h30, "R7 one pm");
        // R6 09 -> 10 and 19 -> 20 (twenty bit)
        roll(8'h59, 8'h59, 8'h09, 8'h02, 8'h15, 8'h06, 8'h30,
             8'h00, 8'h00, 8'h10, 8'h02, 8'h15, 8'h06, 8'h30, "R6 nine");
        roll(8'h59, 8'h59, 8'h19, 8'h02, 8'h15, 8'h06, 8'h30,
             8'h00, 8'h00, 8'h20, 8'h02, 8'h15, 8'h06, 8'h30, "R6 twenty");
        // R12 minute carry without hour wrap
        roll(8'h59, 8'h12, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30,
             8'h00, 8'h13, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30, "R12 minute carry");
        // R2 R12 no carry when seconds do not wrap
        roll(8'h38, 8'h12, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30,
             8'h39, 8'h12, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30, "R2 R12 no carry");

        // R3 halt freezes everything and keeps square wave low
        sqw_en = 1'b1;
        wr(F_SEC, 8'h85);
        repeat (3 * HZ) @(negedge clk);
        push(F_SEC, 8'h85, "R3 halted sec"); push(F_MIN, 8'h12, "R3 halted min");
        push(7, 8'h00, "R3 R5 halted sqw");
        flush();

        // R11 masked loads, read next cycle
        wr(F_DOW, 8'hFD);
        push(F_DOW, 8'h05, "R11 dow mask"); flush();
        wr(F_MIN, 8'hA7);
        push(F_MIN, 8'h27, "R11 min mask"); flush();
        wr(F_YEAR, 8'h42);
        push(F_YEAR, 8'h42, "R11 year load"); flush();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule